// File: doc/BRIEF.md
# Self-Calibrating Sigma-Delta Conversion Sequencer

The block sits behind a one-bit sigma-delta modulator that makes one up/down feedback decision per clock. It steers the converter's input selector through a fixed cycle of three sources: the ground reference, the pin under measurement, and the supply reference. For each source it counts the ones in the bitstream over a window of 2^N clocks. Before each counted window it discards one whole window of the same length so that the modulator can settle after the selector moves.

From each triple of counts the block forms a reading that is corrected for both offset and gain. The ground count maps to zero and the supply count maps to 2^16. The reading is signed, so an input slightly below ground or slightly above the supply gives a value outside 0..65536. Because all three counts come from the same converter and are taken back to back, slow drift cancels out. Optionally, 2^A consecutive readings are averaged before one result is presented. This lowers noise at the cost of output rate.

Top module: `sd_cal_sequencer`

## Requirements
- R1: `src_sel` uses the codes 0 = ground reference, 1 = pin, 2 = supply reference, and never shows 3. The sequence is always 0, then 1, then 2, then back to 0. Each code is held for exactly two windows while measuring: one discarded settle window, then one counted window.
- R2: A raw count is the number of cycles with `sd_bit` high inside the counted window of 2^N cycles. It depends only on the bits sampled while that source is selected.
- R3: Each reading is computed as ((pin − gnd) · 2^16) / (sup − gnd), where the division truncates toward zero. The reading is a signed value, so pin < gnd gives a negative result and pin > sup gives a result above 65536.
- R4: A triple with sup ≤ gnd contributes a reading of zero, and `cal_err` is high with the result that contains it.
- R5: With `avg_exp` = A, the result is the sum of 2^A consecutive readings shifted right arithmetically by A. A is limited to at most 4, so larger codes behave as 4.
- R6: The window exponent N is `win_exp`, limited to at most MAXLOG. With A = 0, consecutive `res_valid` pulses are 6·2^N + MAXLOG + FRAC + 4 cycles apart.
- R7: `res_valid` is a single-cycle pulse. `result` and `cal_err` change only in the cycle in which `res_valid` is high.
- R8: A change on `win_exp` or `avg_exp` is sampled only at the start of the next triple. The triple in progress keeps the old setting.
- R9: During and right after reset, `res_valid`, `result`, `cal_err` and `src_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator decision per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_bit | input | 1 | Modulator bitstream |
| win_exp | input | $clog2(MAXLOG+1) | Window exponent N |
| avg_exp | input | $clog2(MAXAVG+1) | Averaging exponent A |
| src_sel | output | 2 | Input selector code (0 gnd, 1 pin, 2 supply) |
| result | output | MAXLOG+FRAC+2 | Signed calibrated (averaged) reading |
| cal_err | output | 1 | A triple in this result had sup ≤ gnd |
| res_valid | output | 1 | One-cycle strobe for result and cal_err |

## Verification
The embedded assertions take for granted that `sd_bit` is a clean 0 or 1 on every clock. They place no assumption on the configuration inputs, because those inputs are only sampled at triple boundaries. The bench drives each source from a first-order phase-accumulator model with a density in 256ths of full scale. Every counted window is a multiple of 256 cycles, so each raw count is exact and every expected reading can be computed in plain integer arithmetic. Reference levels and configuration are changed only in the cycle right after a result strobe. This keeps each averaging group built from a single setting. The one exception is the deliberate mid-triple change that tests R8.

// File: rtl/sd_cal_sequencer.sv
module sd_cal_sequencer #(
  parameter int MAXLOG = 16,
  parameter int FRAC   = 16,
  parameter int MAXAVG = 4,
  localparam int NW = $clog2(MAXLOG + 1),
  localparam int AVW = $clog2(MAXAVG + 1),
  localparam int CW = MAXLOG + 1,
  localparam int QW = CW + FRAC,
  localparam int RW = QW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sd_bit,
  input  logic [NW-1:0]        win_exp,
  input  logic [AVW-1:0]       avg_exp,
  output logic [1:0]           src_sel,
  output logic signed [RW-1:0] result,
  output logic                 cal_err,
  output logic                 res_valid
);
  localparam int AW = RW + MAXAVG;
  localparam int DCW = $clog2(QW);

  typedef enum logic [1:0] {START, MEAS, PREP, DIV} st_t;
  st_t st;
  logic accp;

  logic [NW-1:0]  n_q;
  logic [AVW-1:0] a_q;
  logic [1:0]     src;
  logic           settle;
  logic [CW-1:0]  tmr, cnt, gnd_c, pin_c, sup_c;
  logic [CW-1:0]  den_q, rem;
  logic [QW-1:0]  num, quo;
  logic [DCW-1:0] dcnt;
  logic           neg, bad;
  logic signed [AW-1:0] acc;
  logic [MAXAVG-1:0]    avn;
  logic                 errs;

  wire [CW-1:0] lim  = (CW'(1) << n_q) - CW'(1);
  wire          last = (tmr == lim);
  wire [CW-1:0] cnt_n = cnt + CW'(sd_bit);

  wire signed [CW:0] diff_w = $signed({1'b0, pin_c}) - $signed({1'b0, gnd_c});
  wire signed [CW:0] den_w  = $signed({1'b0, sup_c}) - $signed({1'b0, gnd_c});
  wire signed [CW:0] mag_w  = diff_w < 0 ? -diff_w : diff_w;

  wire [CW:0] trial = {rem, num[QW-1]};
  wire [CW:0] sub   = trial - {1'b0, den_q};
  wire        ge    = trial >= {1'b0, den_q};

  wire signed [RW-1:0] q_mag = $signed({1'b0, quo});
  wire signed [RW-1:0] q_w   = bad ? '0 : (neg ? -q_mag : q_mag);
  wire signed [AW-1:0] acc_n = acc + AW'(q_w);
  wire [MAXAVG-1:0]    avlim = MAXAVG'((1 << a_q) - 1);

  assign src_sel = (st == MEAS) ? src : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= START; accp <= 1'b0;
      n_q <= '0; a_q <= '0; src <= '0; settle <= 1'b1;
      tmr <= '0; cnt <= '0; gnd_c <= '0; pin_c <= '0; sup_c <= '0;
      den_q <= '0; rem <= '0; num <= '0; quo <= '0; dcnt <= '0;
      neg <= 1'b0; bad <= 1'b0;
      acc <= '0; avn <= '0; errs <= 1'b0;
      result <= '0; cal_err <= 1'b0; res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (accp) begin
        accp <= 1'b0;
        if (avn == avlim) begin
          result    <= RW'(acc_n >>> a_q);
          cal_err   <= errs | bad;
          res_valid <= 1'b1;
          acc <= '0; avn <= '0; errs <= 1'b0;
        end else begin
          acc <= acc_n; avn <= avn + 1'b1; errs <= errs | bad;
        end
      end
      case (st)
        START: begin
          n_q <= (win_exp > NW'(MAXLOG)) ? NW'(MAXLOG) : win_exp;
          a_q <= (avg_exp > AVW'(MAXAVG)) ? AVW'(MAXAVG) : avg_exp;
          src <= 2'd0; settle <= 1'b1; tmr <= '0; cnt <= '0;
          st <= accp ? START : MEAS;
        end
        MEAS: begin
          if (!settle) cnt <= cnt_n;
          if (last) begin
            tmr <= '0;
            if (settle) settle <= 1'b0;
            else begin
              settle <= 1'b1;
              cnt <= '0;
              case (src)
                2'd0: gnd_c <= cnt_n;
                2'd1: pin_c <= cnt_n;
                default: sup_c <= cnt_n;
              endcase
              if (src == 2'd2) begin
                src <= 2'd0; st <= PREP;
              end else src <= src + 2'd1;
            end
          end else tmr <= tmr + 1'b1;
        end
        PREP: begin
          bad   <= den_w <= 0;
          neg   <= diff_w < 0;
          den_q <= den_w[CW-1:0];
          num   <= {mag_w[CW-1:0], FRAC'(0)};
          rem   <= '0; quo <= '0; dcnt <= '0;
          st    <= DIV;
        end
        default: begin
          rem  <= ge ? sub[CW-1:0] : trial[CW-1:0];
          quo  <= {quo[QW-2:0], ge};
          num  <= {num[QW-2:0], 1'b0};
          dcnt <= dcnt + 1'b1;
          if (dcnt == DCW'(QW - 1)) begin
            st <= START; accp <= 1'b1;
          end
        end
      endcase
    end
  end

  // R1
  selector_code_chk: assert property (@(posedge clk) disable iff (rst) src_sel != 2'd3);
  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == MEAS && tmr != '0) |-> $stable(src_sel));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == MEAS && !settle) |-> cnt <= tmr);
  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($stable(result) && $stable(cal_err)) |-> res_valid);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != START) |=> ($stable(n_q) && $stable(a_q)));
  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (accp && bad) |-> q_w == '0);
endmodule

// File: tb/sd_cal_sequencer_bench.sv
module sd_cal_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXLOG = 10;
  localparam int FRAC = 16;
  localparam int MAXAVG = 4;
  localparam int NW = $clog2(MAXLOG + 1);
  localparam int AVW = $clog2(MAXAVG + 1);
  localparam int RW = MAXLOG + 1 + FRAC + 1;
  localparam longint OVH = MAXLOG + FRAC + 4;

  logic clk = 1'b0, rst = 1'b1, sd_bit = 1'b0;
  logic [NW-1:0] win_exp = NW'(8);
  logic [AVW-1:0] avg_exp = '0;
  logic [1:0] src_sel;
  logic signed [RW-1:0] result;
  logic cal_err, res_valid;

  sd_cal_sequencer #(.MAXLOG(MAXLOG), .FRAC(FRAC), .MAXAVG(MAXAVG)) u_sd_cal_sequencer (
    .clk(clk), .rst(rst), .sd_bit(sd_bit), .win_exp(win_exp), .avg_exp(avg_exp),
    .src_sel(src_sel), .result(result), .cal_err(cal_err), .res_valid(res_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int g_lvl = 32, p_lvl = 128, v_lvl = 224, p_step = 0;
  int tri_cnt = 0, tri_base = 0;
  int phase = 0;
  logic [1:0] prev_sel = 2'd0;
  int illegal = 0, run1 = 0, first_pin_run = -1;

  function automatic int clamp_lvl(int x);
    return x < 0 ? 0 : (x > 256 ? 256 : x);
  endfunction

  always @(negedge clk) begin
    int lvl, sum;
    if (!rst) begin
      if (src_sel != prev_sel &&
          !((prev_sel == 2'd0 && src_sel == 2'd1) || (prev_sel == 2'd1 && src_sel == 2'd2) ||
            (prev_sel == 2'd2 && src_sel == 2'd0)))
        illegal++;
      if (src_sel == 2'd3) illegal++;
      if (prev_sel == 2'd2 && src_sel == 2'd0) tri_cnt++;
      if (src_sel == 2'd1) run1++;
      if (prev_sel == 2'd1 && src_sel == 2'd2) begin
        if (first_pin_run < 0) first_pin_run = run1;
        run1 = 0;
      end
      prev_sel = src_sel;
    end
    lvl = (src_sel == 2'd0) ? g_lvl : (src_sel == 2'd2) ? v_lvl
        : clamp_lvl(p_lvl + p_step * (tri_cnt - tri_base));
    sum = phase + lvl;
    sd_bit = (sum >= 256);
    phase = sum % 256;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint reading(int g, int p, int v, int n);
    longint cg, cp, cv;
    cg = longint'(g) * (longint'(1) << n) / 256;
    cp = longint'(p) * (longint'(1) << n) / 256;
    cv = longint'(v) * (longint'(1) << n) / 256;
    if (cv <= cg) return 0;
    return ((cp - cg) * 65536) / (cv - cg);
  endfunction

  task automatic wait_valid();
    do @(negedge clk); while (!res_valid);
  endtask

  task automatic run_case(input int n, input int a, input int g, input int p, input int v,
                          input int st, input string req);
    int ne, ae;
    longint sum, expv;
    bit ee;
    win_exp = NW'(n); avg_exp = AVW'(a);
    g_lvl = g; p_lvl = p; v_lvl = v; p_step = st; tri_base = tri_cnt;
    ne = n > MAXLOG ? MAXLOG : n;
    ae = a > MAXAVG ? MAXAVG : a;
    sum = 0; ee = 1'b0;
    for (int t = 0; t < (1 << ae); t++) begin
      sum += reading(g, clamp_lvl(p + st * t), v, ne);
      if (v <= g) ee = 1'b1;
    end
    expv = sum >>> ae;
    wait_valid();
    check(longint'(result) == expv, req, longint'(result), expv);
    check(cal_err == ee, req, longint'(cal_err), longint'(ee));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    longint c1, c2, c3, c4, c5;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(res_valid == 1'b0 && result == '0 && cal_err == 1'b0 && src_sel == 2'd0, "R9",
          longint'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && result == '0 && src_sel == 2'd0, "R9", longint'(src_sel), 0);

    run_case(8, 0, 32, 128, 224, 0, "R3 mid-scale");
    // R1 pin held for settle + count windows
    check(first_pin_run == 512, "R1", first_pin_run, 512);
    run_case(8, 0, 32, 32, 224, 0, "R3 at ground");
    run_case(8, 0, 32, 224, 224, 0, "R3 at supply");
    run_case(8, 0, 32, 10, 224, 0, "R3 below ground");
    run_case(9, 0, 30, 250, 220, 0, "R3 above supply");
    run_case(10, 0, 31, 77, 229, 0, "R2 R3 long window");
    run_case(8, 0, 100, 50, 100, 0, "R4 equal refs");
    run_case(8, 0, 150, 50, 100, 0, "R4 inverted refs");
    run_case(8, 1, 150, 60, 90, 7, "R4 averaged error");
    run_case(8, 2, 32, 40, 224, 16, "R5 four-way average");
    run_case(8, 1, 32, 100, 224, 3, "R5 two-way average");
    run_case(8, 7, 20, 0, 240, 15, "R5 clamped sixteen-way average");
    run_case(8, 3, 40, 5, 200, 1, "R5 negative average");

    run_case(8, 0, 32, 128, 224, 0, "R6 setup");
    c1 = cyc;
    wait_valid(); c2 = cyc;
    // R6 result period for N=8
    check(c2 - c1 == 6 * 256 + OVH, "R6", c2 - c1, 6 * 256 + OVH);
    repeat (100) @(negedge clk);
    win_exp = NW'(9);
    wait_valid(); c3 = cyc;
    // R8 triple in flight keeps old window
    check(c3 - c2 == 6 * 256 + OVH, "R8", c3 - c2, 6 * 256 + OVH);
    wait_valid(); c4 = cyc;
    check(c4 - c3 == 6 * 512 + OVH, "R8", c4 - c3, 6 * 512 + OVH);
    win_exp = NW'(15);
    wait_valid(); c5 = cyc;
    // R6 window exponent clamped to MAXLOG
    check(c5 - c4 == 6 * 1024 + OVH, "R6", c5 - c4, 6 * 1024 + OVH);
    check(result == 32768, "R6 clamped reading", longint'(result), 32768);
    @(negedge clk);
    // R7 strobe lasts one cycle
    check(res_valid == 1'b0, "R7", longint'(res_valid), 0);
    // R1 selector order and codes
    check(illegal == 0, "R1", illegal, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule